// File: doc/BRIEF.md
# Implicit-Operand Stack Execution Unit

This unit executes the data-path side of a stack-style processor. All operands sit in a small register stack inside the unit, and a depth counter marks where its top is. Instructions carry no operand fields. A push takes a word from the memory side and places it on the stack. A pop returns the top word to the memory side. A binary arithmetic or logic operation takes the word on top and the word just beneath it. It discards the top word, writes the result over the lower one, and the result becomes the new top.

Every operation takes effect at one clock edge. Values enter and leave the stack only through push and pop. When a push finds the stack full, or when a pop or a binary operation finds too few entries, the unit raises an overflow or underflow pulse for one cycle and leaves the stack as it was. The controller that issues the opcodes decides how to react to these pulses.

Top module: `stack_alu_unit`

## Requirements
- R1: While reset is asserted and after it is released, `depth_o` is 0, `overflow_o`, `underflow_o` and `pop_valid_o` are 0, and `pop_data_o` is 0.
- R2: A push (opcode 3'b001) on a stack that is not full raises `depth_o` by one after the clock edge. The value of `push_data_i` becomes the new top entry.
- R3: A push onto a stack holding DEPTH entries is discarded. `overflow_o` is 1 for the following cycle, and `depth_o` and the stored entries are unchanged.
- R4: A pop (opcode 3'b010) on a stack that is not empty drives the top entry on `pop_data_o`. `pop_valid_o` is 1 for one cycle after the edge, and `depth_o` drops by one.
- R5: A pop on an empty stack sets `underflow_o` for one cycle. `pop_valid_o` stays 0 and `depth_o` stays 0.
- R6: A binary operation with at least two entries replaces the lower entry with (lower OP top) and lowers `depth_o` by one. The result becomes the top. The opcodes are add 3'b011, subtract 3'b100 (lower minus top, modulo 2^WIDTH), and 3'b101, or 3'b110 and xor 3'b111.
- R7: A binary operation with fewer than two entries sets `underflow_o` for one cycle and leaves the depth and all entries unchanged.
- R8: Opcode 3'b000 is a no-operation. It changes neither the depth nor the entries, and no flag or valid pulse follows it.
- R9: The sequence push A, push B, add, pop yields A+B on `pop_data_o` and leaves `depth_o` at its value before the sequence.
- R10: `pop_data_o` holds the last popped value until the next successful pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode for this cycle |
| push_data_i | input | WIDTH | Word to push from memory |
| pop_data_o | output | WIDTH | Last word popped to memory |
| pop_valid_o | output | 1 | Pulse: `pop_data_o` was updated by a pop |
| overflow_o | output | 1 | Pulse: the previous push was rejected because the stack was full |
| underflow_o | output | 1 | Pulse: the previous pop or binary operation lacked entries |
| depth_o | output | $clog2(DEPTH+1) | Number of entries on the stack |

## Verification
The bench builds the unit with DEPTH = 4 and WIDTH = 32. The shallow stack lets a few pushes reach the full boundary and a few pops reach the empty boundary. A long pseudo-random opcode stream therefore crosses both limits many times, and it hits the one-entry case for binary operations as well. The full 32-bit width keeps carry and borrow wrap-around in subtraction and addition visible against the reference queue.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'b000,
    OP_PUSH = 3'b001,
    OP_POP  = 3'b010,
    OP_ADD  = 3'b011,
    OP_SUB  = 3'b100,
    OP_AND  = 3'b101,
    OP_OR   = 3'b110,
    OP_XOR  = 3'b111
  } stk_op_e;

  // Opcodes from add upward consume two entries and leave one
  function automatic logic is_binary(input logic [2:0] op);
    return op >= OP_ADD;
  endfunction

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          push_rej,
  output logic          pop_ok,
  output logic          pop_rej,
  output logic          alu_ok,
  output logic          alu_rej,
  output logic          ovf_q,
  output logic          udf_q,
  output logic          popv_q
);
  import stack_alu_pkg::*;

  logic          full, empty, has_two;
  logic [CW-1:0] count_nxt;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign has_two = (count >= CW'(2));

  assign push_ok  = (op == OP_PUSH) && !full;
  assign push_rej = (op == OP_PUSH) &&  full;
  assign pop_ok   = (op == OP_POP)  && !empty;
  assign pop_rej  = (op == OP_POP)  &&  empty;
  assign alu_ok   = is_binary(op)   &&  has_two;
  assign alu_rej  = is_binary(op)   && !has_two;

  always_comb begin
    count_nxt = count;
    if (push_ok)               count_nxt = count + CW'(1);
    else if (pop_ok || alu_ok) count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
      popv_q <= 1'b0;
    end else begin
      count  <= count_nxt;
      ovf_q  <= push_rej;
      udf_q  <= pop_rej | alu_rej;
      popv_q <= pop_ok;
    end
  end

endmodule

// File: rtl/stack_store.sv
module stack_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    top_addr,
  input  logic [AW-1:0]    below_addr,
  output logic [WIDTH-1:0] top_data,
  output logic [WIDTH-1:0] below_data
);

  logic [WIDTH-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ent[g] <= '0;
      else if (we && waddr == AW'(g))       ent[g] <= wdata;
    end
  end

  assign top_data   = ent[top_addr];
  assign below_data = ent[below_addr];

endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] lower,
  input  logic [WIDTH-1:0] upper,
  output logic [WIDTH-1:0] result
);
  import stack_alu_pkg::*;

  // Lower entry is the left-hand operand: it was pushed first
  function automatic logic [WIDTH-1:0] combine(input logic [2:0] code,
                                               input logic [WIDTH-1:0] a,
                                               input logic [WIDTH-1:0] b);
    case (code)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return a;
    endcase
  endfunction

  assign result = combine(op, lower, upper);

endmodule

// File: rtl/stack_alu_unit.sv
module stack_alu_unit #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             pop_valid_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic [CW-1:0]    depth_o
);

  // Named events, visible to the bound checker
  logic          push_ok, push_rej, pop_ok, pop_rej, alu_ok, alu_rej;
  logic [CW-1:0] count;
  logic [AW-1:0] top_idx, below_idx, wr_idx;
  logic [WIDTH-1:0] top_val, below_val, alu_val, wr_val;
  logic          wr_en;

  stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op_i), .count(count),
    .push_ok(push_ok), .push_rej(push_rej), .pop_ok(pop_ok), .pop_rej(pop_rej),
    .alu_ok(alu_ok), .alu_rej(alu_rej),
    .ovf_q(overflow_o), .udf_q(underflow_o), .popv_q(pop_valid_o)
  );

  assign top_idx   = AW'(count - CW'(1));
  assign below_idx = AW'(count - CW'(2));

  assign wr_en  = push_ok | alu_ok;
  assign wr_idx = push_ok ? AW'(count) : below_idx;
  assign wr_val = push_ok ? push_data_i : alu_val;

  stack_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_idx), .wdata(wr_val),
    .top_addr(top_idx), .below_addr(below_idx),
    .top_data(top_val), .below_data(below_val)
  );

  alu_core #(.WIDTH(WIDTH)) u_alu (
    .op(op_i), .lower(below_val), .upper(top_val), .result(alu_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pop_data_o <= '0;
    else if (pop_ok) pop_data_o <= top_val;
  end

  assign depth_o = count;

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_i,
  input logic [CW-1:0] depth_o,
  input logic          overflow_o,
  input logic          underflow_o,
  input logic          pop_valid_o,
  input logic          push_ok,
  input logic          alu_ok
);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CW'(DEPTH)); // R2

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> depth_o == $past(depth_o) + CW'(1)); // R2

  AST_NO_OVERFLOW_BELOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(depth_o) == CW'(DEPTH)); // R3

  AST_OVERFLOW_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $stable(depth_o)); // R3

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o |-> depth_o == $past(depth_o) - CW'(1)); // R4

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow_o, underflow_o, pop_valid_o})); // R5

  AST_UNDERFLOW_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> $stable(depth_o)); // R7

  AST_ALU_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ok |=> depth_o == $past(depth_o) - CW'(1)); // R6

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'b000 |=> $stable(depth_o) && !overflow_o && !underflow_o && !pop_valid_o); // R8

endmodule

bind stack_alu_unit stack_alu_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .depth_o(depth_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .pop_valid_o(pop_valid_o),
  .push_ok(push_ok), .alu_ok(alu_ok)
);

// File: tb/sim_stack_alu_unit.sv
module sim_stack_alu_unit;
  localparam int DEPTH = 4;
  localparam int WIDTH = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       op_i;
  logic [WIDTH-1:0] push_data_i;
  logic [WIDTH-1:0] pop_data_o;
  logic             pop_valid_o, overflow_o, underflow_o;
  logic [CW-1:0]    depth_o;

  always #5 clk = ~clk;

  stack_alu_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .push_data_i(push_data_i),
    .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o), .depth_o(depth_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Reference model: a queue whose back is the stack top
  int unsigned ref_q[$];
  int unsigned e_pd;
  bit e_pv, e_ovf, e_udf;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned ref_alu(int code, int unsigned lo, int unsigned hi);
    longint unsigned w;
    w = 0;
    if (code == 3) w = longint'(lo) + longint'(hi);
    if (code == 4) w = (longint'(lo) + 64'h1_0000_0000) - longint'(hi);
    if (code == 5) w = lo & hi;
    if (code == 6) w = lo | hi;
    if (code == 7) w = lo ^ hi;
    return int'(w[31:0]);
  endfunction

  task automatic step(int code, int unsigned d);
    string tag;
    int unsigned t, b;
    op_i = 3'(code);
    push_data_i = d;
    e_pv = 0; e_ovf = 0; e_udf = 0;
    if (code == 0) tag = "R8";
    else if (code == 1) begin
      if (ref_q.size() == DEPTH) begin e_ovf = 1; tag = "R3"; end
      else begin ref_q.push_back(d); tag = "R2"; end
    end else if (code == 2) begin
      if (ref_q.size() == 0) begin e_udf = 1; tag = "R5"; end
      else begin e_pd = ref_q.pop_back(); e_pv = 1; tag = "R4"; end
    end else begin
      if (ref_q.size() < 2) begin e_udf = 1; tag = "R7"; end
      else begin
        t = ref_q.pop_back(); b = ref_q.pop_back();
        ref_q.push_back(ref_alu(code, b, t)); tag = "R6";
      end
    end
    @(negedge clk);
    chk(tag, "depth", depth_o, ref_q.size());
    chk(tag, "overflow", overflow_o, e_ovf);
    chk(tag, "underflow", underflow_o, e_udf);
    chk(tag, "pop_valid", pop_valid_o, e_pv);
    chk(e_pv ? tag : "R10", "pop_data", pop_data_o, e_pd);
    op_i = 3'd0;
  endtask

  task automatic drain_check();
    while (ref_q.size() > 0) step(2, 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int unsigned lfsr;
    int unsigned a, bv, d0;
    rst_n = 1'b0; op_i = 3'd0; push_data_i = '0; e_pd = 0;
    repeat (3) @(negedge clk);
    chk("R1", "depth in reset", depth_o, 0);
    chk("R1", "flags in reset", {overflow_o, underflow_o, pop_valid_o}, 0);
    chk("R1", "pop_data in reset", pop_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "depth after release", depth_o, 0);

    // Empty-stack rejections
    step(2, 0);
    step(3, 0);
    step(1, 32'h11);
    step(7, 0);          // R7: one entry only
    step(0, 0);          // R8
    // Fill to the limit and overflow
    step(1, 32'h22); step(1, 32'h5); step(1, 32'h7);
    step(1, 32'hDEAD);   // R3: full
    step(2, 0);          // R4: top must be 7, pushed value discarded
    chk("R3", "discarded push not stored", pop_data_o, 32'h7);
    // Each binary operator
    step(1, 32'h3);
    step(4, 0);          // 5 - 3
    step(1, 32'hF0F0_F0F0); step(5, 0);
    step(1, 32'h0F0F_0F0F); step(6, 0);
    step(1, 32'hFFFF_FFFF); step(7, 0);
    drain_check();
    // Borrow and carry wrap
    step(1, 32'h1); step(1, 32'h2); step(4, 0); step(2, 0);
    chk("R6", "sub wraps", pop_data_o, 32'hFFFF_FFFF);
    step(1, 32'hFFFF_FFFF); step(1, 32'h2); step(3, 0); step(2, 0);
    chk("R6", "add wraps", pop_data_o, 32'h1);
    // R10: hold across idle cycles and rejected pops
    step(0, 0); step(2, 0); step(0, 0);
    chk("R10", "pop_data held", pop_data_o, 32'h1);
    // R9 sequence on a non-empty stack
    step(1, 32'h9);
    d0 = ref_q.size();
    a = 32'h1234_5678; bv = 32'h8765_4321;
    step(1, a); step(1, bv); step(3, 0); step(2, 0);
    chk("R9", "sum popped", pop_data_o, a + bv);
    chk("R9", "depth restored", depth_o, d0);
    drain_check();
    // Pseudo-random stream
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(int'(lfsr[2:0]), lfsr * 32'h9E37_79B9);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule